// File: doc/BRIEF.md
# Interrupt Table Entry Fetch and Validator

This block takes one index into an interrupt remap table in memory, fetches the 128-bit entry stored there and decides whether the interrupt may be delivered. The entry address is the table base plus sixteen bytes per entry. The block issues one read on a simple request/response memory port and then checks the response. It first looks for a read error, then for a clear present bit, then for non-zero reserved bits, and last for a source-ID policy violation. Only the first failure is reported.

The source-ID policy is set by a 2-bit type field in the entry. One type allows any source. One compares the requester ID with the entry's ID under a mask chosen by a qualifier, so that the low function bits can be ignored. One accepts any requester whose bus number lies inside a bus range stored in the entry. The fourth type always rejects. If the requester ID is the reserved "unknown" code, the policy check is skipped. When the extended destination mode is off, the destination is cut down to an 8-bit ID.

The caller pulses `start` with the index, the table base, the requester ID and the destination mode. It waits for the one-cycle `done` pulse and then reads either a fault code or the decoded delivery fields. These results stay put until the next fetch completes.

Top module: `intr_entry_fetch`

## Requirements
- R1: One cycle after an accepted `start`, `mem_req_valid` is high for exactly one cycle, with `mem_req_addr` = `table_base` + `entry_index` × 16.
- R2: `busy` is high from the cycle after an accepted `start` until the cycle after the response. A `start` while busy is ignored and issues no request.
- R3: A response with `mem_rsp_err` set gives fault code 1 (table read failure), whatever the data holds.
- R4: When there is no read error and entry bit 0 (present) is clear, the fault code is 2 (entry absent). This takes priority over reserved bits.
- R5: A present entry with any set bit in 15:7, 31:24 or 127:84 gives fault code 3 (reserved bits set). This takes priority over the source-ID check.
- R6: When the requester ID equals 16'hFFFF (unknown), no source-ID check is made, whatever the policy type.
- R7: Policy type (bits 83:82) 0 accepts any requester. Type 1 compares the requester ID with the entry ID (bits 79:64) under a mask chosen by the qualifier (bits 81:80): 0 → 16'hFFFF, 1 → 16'hFFFB, 2 → 16'hFFF9, 3 → 16'hFFF8. A mismatch gives fault code 4.
- R8: Policy type 2 reads entry ID bits 15:8 as the highest and bits 7:0 as the lowest allowed bus, both inclusive. A requester bus (ID bits 15:8) outside that range gives fault code 4.
- R9: Policy type 3 always gives fault code 4.
- R10: On success the fault code is 0 and the decoded fields come from the entry: redirection hint bit 1, destination mode bit 2, trigger mode bit 3, delivery mode bits 6:4, vector bits 23:16, destination bits 63:32. On any fault all decoded fields are zero.
- R11: With `ext_dest_mode` low, `dest_id` is entry bits 47:40 in bits 7:0, with the upper bits zero. With it high, `dest_id` is the full 32-bit field.
- R12: `done` is a one-cycle pulse in the cycle after the response is accepted. The fault code and fields change only then, and they hold while idle. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a fetch (accepted when idle) |
| entry_index | input | IDX_W | Table index to fetch |
| table_base | input | ADDR_W | Byte address of table entry 0 |
| requester_id | input | 16 | Source ID of the interrupt requester (16'hFFFF = unknown) |
| ext_dest_mode | input | 1 | 1 = full 32-bit destination, 0 = 8-bit destination |
| mem_req_valid | output | 1 | Read request strobe |
| mem_req_addr | output | ADDR_W | Read byte address |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 128 | Entry contents |
| mem_rsp_err | input | 1 | Read failed |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | Result valid pulse |
| fault_code | output | 3 | 0 ok, 1 read failure, 2 absent, 3 reserved, 4 source rejected |
| vector | output | 8 | Decoded vector |
| trigger_mode | output | 1 | Decoded trigger mode |
| delivery_mode | output | 3 | Decoded delivery mode |
| dest_mode | output | 1 | Decoded destination mode |
| redir_hint | output | 1 | Decoded redirection hint |
| dest_id | output | 32 | Decoded destination, narrowed when extended mode is off |

## Verification
The hardest situations to reach are the ones where two fault conditions occur together, because only the ordering decides the result. Examples are a read error carrying an absent entry, an absent entry with reserved bits set, and a reserved violation on an entry whose policy would also reject. The bench loads a memory model with entries built to hold several defects at once and sets the error flag per response. It also lengthens the response latency so that a second `start` can land while a fetch is still outstanding. The mask qualifiers and the bus range are driven exactly at their edges: one differing bit inside and one outside the mask, and the minimum, the maximum and one beyond each.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;

    localparam int ENTRY_W     = 128;
    localparam int ENTRY_SHIFT = $clog2(ENTRY_W / 8);
    localparam int SID_W       = 16;
    localparam int BUS_W       = SID_W / 2;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_ROOT   = 3'd1,
        FLT_ABSENT = 3'd2,
        FLT_RSVD   = 3'd3,
        FLT_SOURCE = 3'd4
    } fault_e;

    typedef struct packed {
        logic [31:0] dest;
        logic [7:0]  vector;
        logic [2:0]  dlvr;
        logic        trig;
        logic        dmode;
        logic        hint;
    } deliv_t;

    typedef struct packed {
        logic [SID_W-1:0] sid;
        logic [1:0]       qual;
        logic [1:0]       vtype;
    } srcpol_t;

endpackage

// File: rtl/entry_decode.sv
module entry_decode
    import intr_entry_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  logic               ext_mode,
    output logic               present,
    output logic               rsvd_nz,
    output deliv_t             fields,
    output srcpol_t            pol
);

    assign present = entry[0];
    assign rsvd_nz = (|entry[15:7]) | (|entry[31:24]) | (|entry[127:84]);

    always_comb begin
        fields.hint   = entry[1];
        fields.dmode  = entry[2];
        fields.trig   = entry[3];
        fields.dlvr   = entry[6:4];
        fields.vector = entry[23:16];
        if (ext_mode) begin
            fields.dest = entry[63:32];
        end else begin
            fields.dest = {24'b0, entry[47:40]};
        end
        pol.sid   = entry[79:64];
        pol.qual  = entry[81:80];
        pol.vtype = entry[83:82];
    end

endmodule

// File: rtl/source_check.sv
module source_check
    import intr_entry_pkg::*;
(
    input  srcpol_t          pol,
    input  logic [SID_W-1:0] req_id,
    input  logic             check_en,
    output logic             pass
);

    logic [SID_W-1:0] cmp_mask;
    logic [BUS_W-1:0] req_bus;
    logic [BUS_W-1:0] bus_lo;
    logic [BUS_W-1:0] bus_hi;

    // Qualifier q ignores the top q bits of the 3-bit function number.
    always_comb begin
        cmp_mask = '1;
        for (int b = 0; b < 3; b++) begin
            if (int'(pol.qual) >= 3 - b) begin
                cmp_mask[b] = 1'b0;
            end
        end
    end

    assign req_bus = req_id[SID_W-1:BUS_W];
    assign bus_hi  = pol.sid[SID_W-1:BUS_W];
    assign bus_lo  = pol.sid[BUS_W-1:0];

    always_comb begin
        if (!check_en) begin
            pass = 1'b1;
        end else begin
            unique case (pol.vtype)
                2'd0:    pass = 1'b1;
                2'd1:    pass = ((req_id ^ pol.sid) & cmp_mask) == '0;
                2'd2:    pass = (req_bus >= bus_lo) && (req_bus <= bus_hi);
                default: pass = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/intr_entry_fetch.sv
module intr_entry_fetch
    import intr_entry_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16,
    parameter logic [15:0] SID_UNKNOWN = 16'hFFFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [IDX_W-1:0]    entry_index,
    input  logic [ADDR_W-1:0]   table_base,
    input  logic [15:0]         requester_id,
    input  logic                ext_dest_mode,
    output logic                mem_req_valid,
    output logic [ADDR_W-1:0]   mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [127:0]        mem_rsp_data,
    input  logic                mem_rsp_err,
    output logic                busy,
    output logic                done,
    output logic [2:0]          fault_code,
    output logic [7:0]          vector,
    output logic                trigger_mode,
    output logic [2:0]          delivery_mode,
    output logic                dest_mode,
    output logic                redir_hint,
    output logic [31:0]         dest_id
);

    typedef enum logic {ST_IDLE, ST_WAIT} fstate_e;

    typedef struct packed {
        fstate_e          st;
        logic             req;
        logic [ADDR_W-1:0] addr;
        logic [SID_W-1:0] sid;
        logic             ext;
        logic             done;
        fault_e           fault;
        deliv_t           out;
    } regs_t;

    regs_t   d, q;
    logic    ent_present;
    logic    ent_rsvd;
    deliv_t  ent_fields;
    srcpol_t ent_pol;
    logic    src_pass;

    entry_decode dec_i (
        .entry    (mem_rsp_data),
        .ext_mode (q.ext),
        .present  (ent_present),
        .rsvd_nz  (ent_rsvd),
        .fields   (ent_fields),
        .pol      (ent_pol)
    );

    source_check src_i (
        .pol      (ent_pol),
        .req_id   (q.sid),
        .check_en (q.sid != SID_UNKNOWN),
        .pass     (src_pass)
    );

    always_comb begin
        d      = q;
        d.req  = 1'b0;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st   = ST_WAIT;
                    d.req  = 1'b1;
                    d.addr = table_base + (ADDR_W'(entry_index) << ENTRY_SHIFT);
                    d.sid  = requester_id;
                    d.ext  = ext_dest_mode;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    if (mem_rsp_err) begin
                        d.fault = FLT_ROOT;
                    end else if (!ent_present) begin
                        d.fault = FLT_ABSENT;
                    end else if (ent_rsvd) begin
                        d.fault = FLT_RSVD;
                    end else if (!src_pass) begin
                        d.fault = FLT_SOURCE;
                    end else begin
                        d.fault = FLT_NONE;
                    end
                    d.out = (d.fault == FLT_NONE) ? ent_fields : '0;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_req_valid = q.req;
    assign mem_req_addr  = q.addr;
    assign busy          = (q.st == ST_WAIT);
    assign done          = q.done;
    assign fault_code    = q.fault;
    assign vector        = q.out.vector;
    assign trigger_mode  = q.out.trig;
    assign delivery_mode = q.out.dlvr;
    assign dest_mode     = q.out.dmode;
    assign redir_hint    = q.out.hint;
    assign dest_id       = q.out.dest;

    // R1
    req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R2
    busy_until_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_rsp_valid) |=> busy);

    // R10
    fault_zero_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_code != 3'd0) |-> (vector == 8'd0 && dest_id == 32'd0));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(fault_code) && $stable(dest_id) && $stable(vector)));

endmodule

// File: tb/intr_entry_fetch_tb.sv
module intr_entry_fetch_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [15:0]  entry_index = '0;
    logic [31:0]  table_base = 32'h0004_0000;
    logic [15:0]  requester_id = '0;
    logic         ext_dest_mode = 1'b0;
    logic         mem_req_valid;
    logic [31:0]  mem_req_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [127:0] mem_rsp_data = '0;
    logic         mem_rsp_err = 1'b0;
    logic         busy, done, trigger_mode, dest_mode, redir_hint;
    logic [2:0]   fault_code, delivery_mode;
    logic [7:0]   vector;
    logic [31:0]  dest_id;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_entry_fetch dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .entry_index(entry_index),
        .table_base(table_base), .requester_id(requester_id),
        .ext_dest_mode(ext_dest_mode), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err), .busy(busy),
        .done(done), .fault_code(fault_code), .vector(vector),
        .trigger_mode(trigger_mode), .delivery_mode(delivery_mode),
        .dest_mode(dest_mode), .redir_hint(redir_hint), .dest_id(dest_id)
    );

    int n_chk = 0;
    int n_fail = 0;
    string cur_tag = "R12";

    logic [127:0] mem_ent [16];
    int  lat = 0;
    bit  err_flag = 1'b0;
    int  pend = -1;
    logic [3:0] slot = '0;

    // reference model state
    bit          m_busy = 1'b0;
    bit          exp_req = 1'b0;
    bit          exp_done = 1'b0;
    logic [31:0] exp_addr = '0;
    logic [15:0] m_sid = '0;
    bit          m_ext = 1'b0;
    int          exp_fault = 0;
    logic [7:0]  exp_vec = '0;
    logic [31:0] exp_dest = '0;
    logic [2:0]  exp_dlvr = '0;
    bit          exp_trig = 1'b0, exp_dm = 1'b0, exp_hint = 1'b0;

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [127:0] mk(bit p, bit hint, bit dm, bit tr, logic [2:0] dl,
                                        logic [7:0] vec, logic [31:0] dst, logic [15:0] sid,
                                        logic [1:0] qual, logic [1:0] vt);
        logic [127:0] e = '0;
        e[0] = p; e[1] = hint; e[2] = dm; e[3] = tr; e[6:4] = dl;
        e[23:16] = vec; e[63:32] = dst; e[79:64] = sid; e[81:80] = qual; e[83:82] = vt;
        return e;
    endfunction

    function automatic int ref_fault(logic [127:0] e, bit err, logic [15:0] sid);
        logic [15:0] msk;
        logic [15:0] esid = e[79:64];
        if (err) return 1;                                              // R3
        if (!e[0]) return 2;                                            // R4
        if (e[15:7] != 0 || e[31:24] != 0 || e[127:84] != 0) return 3; // R5
        if (sid == 16'hFFFF) return 0;                                  // R6
        case (e[83:82])
            2'd0: return 0;
            2'd1: begin                                                 // R7
                case (e[81:80])
                    2'd0: msk = 16'hFFFF;
                    2'd1: msk = 16'hFFFB;
                    2'd2: msk = 16'hFFF9;
                    default: msk = 16'hFFF8;
                endcase
                return ((sid & msk) == (esid & msk)) ? 0 : 4;
            end
            2'd2: return (sid[15:8] > esid[15:8] || sid[15:8] < esid[7:0]) ? 4 : 0; // R8
            default: return 4;                                          // R9
        endcase
    endfunction

    // model advances at the active edge on bench-driven (stable) inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; exp_req = 0; exp_done = 0; exp_fault = 0; exp_vec = 0;
            exp_dest = 0; exp_dlvr = 0; exp_trig = 0; exp_dm = 0; exp_hint = 0;
        end else begin
            exp_req = 0;
            exp_done = 0;
            if (!m_busy && start) begin
                m_busy = 1; exp_req = 1;
                exp_addr = table_base + {entry_index, 4'b0000};
                m_sid = requester_id; m_ext = ext_dest_mode;
            end else if (m_busy && mem_rsp_valid) begin
                m_busy = 0; exp_done = 1;
                exp_fault = ref_fault(mem_rsp_data, mem_rsp_err, m_sid);
                if (exp_fault == 0) begin
                    exp_hint = mem_rsp_data[1]; exp_dm = mem_rsp_data[2];
                    exp_trig = mem_rsp_data[3]; exp_dlvr = mem_rsp_data[6:4];
                    exp_vec = mem_rsp_data[23:16];
                    exp_dest = m_ext ? mem_rsp_data[63:32] : {24'b0, mem_rsp_data[47:40]}; // R11
                end else begin
                    exp_hint = 0; exp_dm = 0; exp_trig = 0; exp_dlvr = 0; exp_vec = 0; exp_dest = 0;
                end
            end
        end
    end

    // memory responder
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        mem_rsp_err = 1'b0;
        mem_rsp_data = '0;
        if (rst_n && mem_req_valid) begin
            pend = lat;
            slot = mem_req_addr[7:4];
        end
        if (pend == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_err = err_flag;
            mem_rsp_data = mem_ent[slot];
            pend = -1;
        end else if (pend > 0) begin
            pend--;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1", "req_valid", 64'(mem_req_valid), 64'(exp_req));
            if (exp_req) chk("R1", "req_addr", 64'(mem_req_addr), 64'(exp_addr));
            chk("R2", "busy", 64'(busy), 64'(m_busy));
            chk("R12", "done", 64'(done), 64'(exp_done));
            chk(cur_tag, "fault_code", 64'(fault_code), 64'(exp_fault));
            chk(cur_tag, "vector", 64'(vector), 64'(exp_vec));
            chk(cur_tag, "dest_id", 64'(dest_id), 64'(exp_dest));
            chk("R10", "fields", 64'({delivery_mode, trigger_mode, dest_mode, redir_hint}),
                64'({exp_dlvr, exp_trig, exp_dm, exp_hint}));
        end
    end

    task automatic fetch(string tag, logic [15:0] idx, logic [15:0] sid, bit ext,
                         int l, bit e, bit second_start);
        @(negedge clk);
        cur_tag = tag;
        lat = l; err_flag = e;
        entry_index = idx; requester_id = sid; ext_dest_mode = ext; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        entry_index = idx + 16'd1;
        if (second_start) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        repeat (l + 3) @(negedge clk);
    endtask

    task automatic run_tests();
        for (int i = 0; i < 16; i++) mem_ent[i] = '0;
        mem_ent[3]  = mk(1, 1, 0, 1, 3'd5, 8'h41, 32'hA1B2C3D4, 16'h0100, 2'd0, 2'd0);
        mem_ent[4]  = mk(0, 1, 1, 1, 3'd2, 8'h55, 32'h0000_1200, 16'h0000, 2'd0, 2'd0);
        mem_ent[4][100] = 1'b1;
        mem_ent[5]  = mk(1, 0, 1, 0, 3'd1, 8'h60, 32'h0000_3300, 16'h0000, 2'd0, 2'd3);
        mem_ent[5][10] = 1'b1;
        mem_ent[6]  = mk(1, 0, 0, 0, 3'd0, 8'h61, 32'h0000_3400, 16'h0000, 2'd0, 2'd0);
        mem_ent[6][120] = 1'b1;
        mem_ent[7]  = mk(1, 0, 1, 1, 3'd7, 8'h70, 32'h1234_5678, 16'h0000, 2'd0, 2'd3);
        mem_ent[8]  = mk(1, 1, 1, 0, 3'd4, 8'h80, 32'h0000_8800, 16'hBEEF, 2'd2, 2'd0);
        mem_ent[9]  = mk(1, 0, 0, 1, 3'd1, 8'h90, 32'h0000_9900, 16'h0310, 2'd0, 2'd1);
        mem_ent[10] = mk(1, 0, 0, 1, 3'd1, 8'hA0, 32'h0000_AA00, 16'h0310, 2'd1, 2'd1);
        mem_ent[11] = mk(1, 0, 0, 1, 3'd1, 8'hB0, 32'h0000_BB00, 16'h0310, 2'd2, 2'd1);
        mem_ent[12] = mk(1, 0, 0, 1, 3'd1, 8'hC0, 32'h0000_CC00, 16'h0310, 2'd3, 2'd1);
        mem_ent[13] = mk(1, 1, 0, 0, 3'd3, 8'hD0, 32'h0000_DD00, 16'h2010, 2'd0, 2'd2);
        mem_ent[14] = mk(1, 0, 0, 0, 3'd0, 8'hE0, 32'h0000_EE00, 16'h0100, 2'd0, 2'd3);
        mem_ent[15] = mk(1, 1, 1, 1, 3'd6, 8'hF3, 32'hCAFE_F00D, 16'h0000, 2'd0, 2'd0);

        repeat (3) @(negedge clk);                       // R12 reset state compared each cycle
        fetch("R10", 16'd3, 16'h0208, 1'b1, 0, 1'b0, 1'b0);
        fetch("R11", 16'd3, 16'h0208, 1'b0, 2, 1'b0, 1'b0);
        fetch("R3",  16'd4, 16'h0000, 1'b1, 1, 1'b1, 1'b0);
        fetch("R3",  16'd3, 16'h0000, 1'b1, 0, 1'b1, 1'b0);
        fetch("R4",  16'd4, 16'h0000, 1'b1, 1, 1'b0, 1'b0);
        fetch("R5",  16'd5, 16'h0100, 1'b1, 0, 1'b0, 1'b0);
        fetch("R5",  16'd6, 16'h0100, 1'b1, 3, 1'b0, 1'b0);
        fetch("R6",  16'd7, 16'hFFFF, 1'b1, 1, 1'b0, 1'b0);
        fetch("R9",  16'd7, 16'hFFFE, 1'b1, 1, 1'b0, 1'b0);
        fetch("R7",  16'd8, 16'h1234, 1'b1, 0, 1'b0, 1'b0);
        fetch("R7",  16'd9, 16'h0310, 1'b1, 0, 1'b0, 1'b0);
        fetch("R7",  16'd9, 16'h0311, 1'b1, 0, 1'b0, 1'b0);
        fetch("R7",  16'd10, 16'h0314, 1'b1, 1, 1'b0, 1'b0);
        fetch("R7",  16'd10, 16'h0312, 1'b1, 1, 1'b0, 1'b0);
        fetch("R7",  16'd11, 16'h0316, 1'b1, 0, 1'b0, 1'b0);
        fetch("R7",  16'd11, 16'h0311, 1'b1, 0, 1'b0, 1'b0);
        fetch("R7",  16'd12, 16'h0317, 1'b1, 2, 1'b0, 1'b0);
        fetch("R7",  16'd12, 16'h0318, 1'b1, 2, 1'b0, 1'b0);
        fetch("R8",  16'd13, 16'h10FF, 1'b1, 0, 1'b0, 1'b0);
        fetch("R8",  16'd13, 16'h2000, 1'b1, 0, 1'b0, 1'b0);
        fetch("R8",  16'd13, 16'h2100, 1'b1, 0, 1'b0, 1'b0);
        fetch("R8",  16'd13, 16'h0F00, 1'b1, 0, 1'b0, 1'b0);
        fetch("R9",  16'd14, 16'h0100, 1'b1, 1, 1'b0, 1'b0);
        fetch("R2",  16'd3, 16'h0208, 1'b1, 5, 1'b0, 1'b1);
        fetch("R1",  16'hFFFF, 16'h0000, 1'b1, 2, 1'b0, 1'b0);
        fetch("R11", 16'hFFFF, 16'h0000, 1'b0, 0, 1'b0, 1'b0);
        cur_tag = "R12";
        repeat (10) @(negedge clk);                      // R12 outputs hold while idle
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork
            run_tests();
            begin
                repeat (WATCHDOG) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule